// File: doc/BRIEF.md
# IO Page Table Walker

The walker turns an IO virtual address into a physical address by reading a radix page table from memory. Each table is one 4 KiB page of 512 eight-byte entries. A request carries the IOVA, a depth code and the physical page number of the root table. The walker then reads one entry per level over a request/response memory port. Each level indexes with nine IOVA bits, starting at the top level. The walk stops at the first leaf. A leaf is an entry with any access bit set, or any valid entry at level 0.

The result comes back as a one-cycle `done` pulse. The pulse carries either the physical address with the leaf's R/W/X/U bits and its level, or a fault cause. The block also supports superpage leaves at every level and a 64 KiB contiguous leaf at level 0. It runs only one walk at a time, and `req_ready` is high only while it is idle.

Top module: `iopt_walker`

## Requirements
- R1: `cfg_mode` 8, 9 and 10 give top levels 2, 3 and 4, which are 39-, 48- and 57-bit IOVAs. The first read goes to `{cfg_root_ppn,12'b0} + 8*iova[9T+20:9T+12]`. Any other code faults with cause 1 at level 0. That fault pulses `done` in the cycle after acceptance, with no memory read.
- R2: With top level T, IOVA bits 63 down to 9T+21 must all equal bit 9T+20. Otherwise the walk faults with cause 2 at level T, with no memory read.
- R3: Every read address is 8-byte aligned. The entry at level L is read at `table_base + 8*iova[9L+20:9L+12]`. A pointer entry (V=1, R=W=X=0, level>0) sets the next `table_base` to entry bits 53:10 shifted left by 12. A walk ending at level L makes T-L+1 reads.
- R4: An entry with bit 0 (V) clear ends the walk with cause 3 at that entry's level.
- R5: A V=1 entry with any of bit 1 (R), bit 2 (W) or bit 3 (X) set is a leaf, and so is any V=1 entry at level 0. On success `done_fault` is 0, `done_level` is the leaf level, and `done_perm` is {bit4 U, X, W, R}, from bit 3 down to bit 0. Bits 5 to 9 and 61 to 62 of the entry do not affect the result.
- R6: A leaf at level L gives `done_pa` = physical address bits 55 down to 12+9L from entry PPN (bits 53:10) shifted left 12, and the lower bits from the IOVA. If the low 9L PPN bits of the leaf are not zero, the walk faults with cause 4.
- R7: A level-0 leaf with bit 63 (N) set and entry bits 13:10 equal to 4'b1000 is a 64 KiB page. `done_pa` = entry bits 53:14 shifted left 16, plus IOVA bits 15:0.
- R8: Bit 63 set in any other case faults with cause 5. That covers N on a pointer, N on a leaf above level 0, N with bits 13:10 not equal to 4'b1000, and N while `NAPOT_EN`=0.
- R9: `req_ready` drops in the cycle after a request is accepted. `done` lasts exactly one cycle. When `done_fault` is not 0, `done_pa` and `done_perm` are zero.
- R10: The walker keeps one read outstanding. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`. The response is taken from the first `mem_rsp_valid` that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_iova | input | VA_W | Address to translate |
| cfg_mode | input | 4 | Depth code (8, 9, 10) |
| cfg_root_ppn | input | PA_W-12 | Root table page number |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | PA_W | Entry byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read |
| done | output | 1 | One-cycle completion pulse |
| done_pa | output | PA_W | Translated address |
| done_perm | output | 4 | {U,X,W,R} |
| done_level | output | 3 | Leaf or fault level |
| done_fault | output | 3 | 0 ok, 1 mode, 2 sign, 3 absent, 4 misaligned, 5 contiguous encoding |

## Verification
Mode and sign faults are decided at the accepting edge, so `done` is high in the very next cycle. A walk that reads memory finishes at the edge that takes the last response, and `done` is high in the cycle after it. Each read needs one cycle to be accepted and returns its response one cycle after that. The bench stubs memory with ready toggling every cycle, so reads see stalls. It polls `done` at falling edges and samples the result fields in the cycle where `done` is seen. It checks in the next cycle that the pulse has dropped, and it counts reads at the memory handshake to compare against the expected depth.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
   localparam int OFS_W   = 12;
   localparam int IDX_W   = 9;
   localparam int LVL_W   = 3;
   localparam int MODE_W  = 4;
   localparam int MODE_BASE = 6;
   localparam int PERM_W  = 4;

   typedef enum logic [2:0] {
      FLT_NONE     = 3'd0,
      FLT_MODE     = 3'd1,
      FLT_CANON    = 3'd2,
      FLT_ABSENT   = 3'd3,
      FLT_MISALIGN = 3'd4,
      FLT_NAPOT    = 3'd5
   } fault_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_FIN   = 2'd3
   } wstate_e;

   typedef struct packed {
      logic u;
      logic x;
      logic w;
      logic r;
   } perm_t;
endpackage

// File: rtl/iopt_mode_decode.sv
module iopt_mode_decode
   import iopt_pkg::*;
#(
   parameter int VA_W    = 64,
   parameter int MIN_TOP = 2,
   parameter int MAX_TOP = 4
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [VA_W-1:0]   iova,
   output logic              mode_ok,
   output logic [LVL_W-1:0]  top_lvl,
   output logic              canon_ok
);
   localparam logic [MODE_W-1:0] LO_CODE = MODE_W'(MODE_BASE + MIN_TOP);
   localparam logic [MODE_W-1:0] HI_CODE = MODE_W'(MODE_BASE + MAX_TOP);

   logic [MAX_TOP:0] canon_lv;

   if (VA_W < 9 * MAX_TOP + 22) begin : g_bad_va
      $error("VA_W too narrow for MAX_TOP");
   end
   if (MIN_TOP < 1 || MIN_TOP > MAX_TOP || MAX_TOP > 4) begin : g_bad_top
      $error("unsupported depth range");
   end

   for (genvar lv = 0; lv <= MAX_TOP; lv++) begin : g_lv
      if (lv < MIN_TOP) begin : g_off
         assign canon_lv[lv] = 1'b0;
      end else begin : g_on
         logic [VA_W-1-(9*lv+20):0] upper;
         assign upper        = iova[VA_W-1:9*lv+20];
         assign canon_lv[lv] = (&upper) | ~(|upper);
      end
   end

   always_comb begin
      mode_ok  = (mode >= LO_CODE) && (mode <= HI_CODE);
      top_lvl  = LVL_W'(mode - MODE_W'(MODE_BASE));
      canon_ok = mode_ok && canon_lv[top_lvl];
   end
endmodule

// File: rtl/iopt_pte_class.sv
module iopt_pte_class
   import iopt_pkg::*;
#(
   parameter int PTE_W    = 64,
   parameter int PPN_W    = 44,
   parameter bit NAPOT_EN = 1'b1
) (
   input  logic [PTE_W-1:0] pte,
   input  logic [LVL_W-1:0] level,
   output logic             present,
   output logic             is_leaf,
   output perm_t            perm,
   output logic [PPN_W-1:0] ppn,
   output logic             napot_leaf,
   output logic             napot_bad
);
   localparam int PPN_LO = 10;
   localparam int PPN_HI = PPN_LO + PPN_W - 1;
   localparam int N_BIT  = PTE_W - 1;

   if (PTE_W != 64 || PPN_HI != 53) begin : g_bad_fmt
      $error("entry layout needs 64-bit entries with PPN in 53:10");
   end

   logic rwx;
   logic n_set;
   logic unused_bits;

   assign unused_bits = ^{pte[N_BIT-1:PPN_HI+1], pte[9:5]};

   always_comb begin
      present  = pte[0];
      rwx      = |pte[3:1];
      is_leaf  = present && (rwx || (level == '0));
      perm     = '{u: pte[4], x: pte[3], w: pte[2], r: pte[1]};
      ppn      = pte[PPN_HI:PPN_LO];
      n_set    = pte[N_BIT];
   end

   if (NAPOT_EN) begin : g_napot
      always_comb begin
         napot_leaf = present && is_leaf && n_set && (level == '0) &&
                      (pte[PPN_LO+3:PPN_LO] == 4'b1000);
         napot_bad  = present && n_set && !napot_leaf;
      end
   end else begin : g_plain
      always_comb begin
         napot_leaf = 1'b0;
         napot_bad  = present && n_set;
      end
   end
endmodule

// File: rtl/iopt_leaf_compose.sv
module iopt_leaf_compose
   import iopt_pkg::*;
#(
   parameter int PA_W    = 56,
   parameter int MAX_TOP = 4
) (
   input  logic [PA_W-OFS_W-1:0] ppn,
   input  logic [LVL_W-1:0]      level,
   input  logic [PA_W-1:0]       va_lo,
   input  logic                  napot,
   output logic [PA_W-1:0]       pa,
   output logic                  misaligned
);
   localparam int PPN_W = PA_W - OFS_W;

   logic [PA_W-1:0] base;
   logic [PA_W-1:0] pa_lv [MAX_TOP+1];
   logic [MAX_TOP:0] mis_lv;
   logic [PA_W-1:0] pa_napot;

   assign base = {ppn, {OFS_W{1'b0}}};

   for (genvar lv = 0; lv <= MAX_TOP; lv++) begin : g_lv
      localparam logic [PA_W-1:0] OMASK =
         PA_W'((64'd1 << (OFS_W + IDX_W * lv)) - 64'd1);
      localparam logic [PPN_W-1:0] PMASK =
         PPN_W'((64'd1 << (IDX_W * lv)) - 64'd1);
      assign pa_lv[lv]  = (base & ~OMASK) | (va_lo & OMASK);
      assign mis_lv[lv] = |(ppn & PMASK);
   end

   assign pa_napot = {ppn[PPN_W-1:4], 16'h0000} |
                     {{(PA_W-16){1'b0}}, va_lo[15:0]};

   always_comb begin
      if (napot) begin
         pa         = pa_napot;
         misaligned = 1'b0;
      end else begin
         pa         = pa_lv[level];
         misaligned = mis_lv[level];
      end
   end
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
   import iopt_pkg::*;
#(
   parameter int VA_W     = 64,
   parameter int PA_W     = 56,
   parameter int PTE_W    = 64,
   parameter int MIN_TOP  = 2,
   parameter int MAX_TOP  = 4,
   parameter bit NAPOT_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [VA_W-1:0]       req_iova,
   input  logic [MODE_W-1:0]     cfg_mode,
   input  logic [PA_W-OFS_W-1:0] cfg_root_ppn,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   output logic [PA_W-1:0]       mem_req_addr,
   input  logic                  mem_rsp_valid,
   input  logic [PTE_W-1:0]      mem_rsp_data,
   output logic                  done,
   output logic [PA_W-1:0]       done_pa,
   output logic [PERM_W-1:0]     done_perm,
   output logic [LVL_W-1:0]      done_level,
   output logic [2:0]            done_fault
);
   localparam int PPN_W = PA_W - OFS_W;

   if (PA_W != 56) begin : g_bad_pa
      $error("output address must be 56 bits");
   end

   wstate_e              st;
   logic [VA_W-1:0]      iova_q;
   logic [LVL_W-1:0]     lvl_q;
   logic [PA_W-1:0]      base_q;
   logic [PA_W-1:0]      pa_q;
   perm_t                perm_q;
   fault_e               fault_q;

   logic                 mode_ok;
   logic [LVL_W-1:0]     top_lvl;
   logic                 canon_ok;

   logic                 e_present;
   logic                 e_leaf;
   perm_t                e_perm;
   logic [PPN_W-1:0]     e_ppn;
   logic                 e_napot;
   logic                 e_napot_bad;

   logic [PA_W-1:0]      leaf_pa;
   logic                 leaf_mis;

   logic [IDX_W-1:0]     idx_lv [MAX_TOP+1];
   logic [IDX_W-1:0]     idx_cur;

   iopt_mode_decode #(
      .VA_W(VA_W), .MIN_TOP(MIN_TOP), .MAX_TOP(MAX_TOP)
   ) u_mode (
      .mode(cfg_mode), .iova(req_iova),
      .mode_ok(mode_ok), .top_lvl(top_lvl), .canon_ok(canon_ok)
   );

   iopt_pte_class #(
      .PTE_W(PTE_W), .PPN_W(PPN_W), .NAPOT_EN(NAPOT_EN)
   ) u_class (
      .pte(mem_rsp_data), .level(lvl_q),
      .present(e_present), .is_leaf(e_leaf), .perm(e_perm),
      .ppn(e_ppn), .napot_leaf(e_napot), .napot_bad(e_napot_bad)
   );

   iopt_leaf_compose #(
      .PA_W(PA_W), .MAX_TOP(MAX_TOP)
   ) u_comp (
      .ppn(e_ppn), .level(lvl_q), .va_lo(iova_q[PA_W-1:0]),
      .napot(e_napot), .pa(leaf_pa), .misaligned(leaf_mis)
   );

   for (genvar lv = 0; lv <= MAX_TOP; lv++) begin : g_idx
      assign idx_lv[lv] = iova_q[OFS_W + IDX_W*lv +: IDX_W];
   end
   assign idx_cur = idx_lv[lvl_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         iova_q  <= '0;
         lvl_q   <= '0;
         base_q  <= '0;
         pa_q    <= '0;
         perm_q  <= '0;
         fault_q <= FLT_NONE;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  iova_q  <= req_iova;
                  base_q  <= {cfg_root_ppn, {OFS_W{1'b0}}};
                  pa_q    <= '0;
                  perm_q  <= '0;
                  fault_q <= FLT_NONE;
                  if (!mode_ok) begin
                     lvl_q   <= '0;
                     fault_q <= FLT_MODE;
                     st      <= ST_FIN;
                  end else if (!canon_ok) begin
                     lvl_q   <= top_lvl;
                     fault_q <= FLT_CANON;
                     st      <= ST_FIN;
                  end else begin
                     lvl_q   <= top_lvl;
                     st      <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               if (mem_req_ready) st <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!e_present) begin
                     fault_q <= FLT_ABSENT;
                     st      <= ST_FIN;
                  end else if (e_napot_bad) begin
                     fault_q <= FLT_NAPOT;
                     st      <= ST_FIN;
                  end else if (e_leaf) begin
                     if (leaf_mis) begin
                        fault_q <= FLT_MISALIGN;
                     end else begin
                        pa_q   <= leaf_pa;
                        perm_q <= e_perm;
                     end
                     st <= ST_FIN;
                  end else begin
                     base_q <= {e_ppn, {OFS_W{1'b0}}};
                     lvl_q  <= lvl_q - LVL_W'(1);
                     st     <= ST_ISSUE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready     = (st == ST_IDLE);
      mem_req_valid = (st == ST_ISSUE);
      mem_req_addr  = base_q | {{(PA_W-OFS_W){1'b0}}, idx_cur, 3'b000};
      done          = (st == ST_FIN);
      done_pa       = pa_q;
      done_perm     = perm_q;
      done_level    = lvl_q;
      done_fault    = fault_q;
   end
endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk #(
   parameter int PA_W    = 56,
   parameter int MAX_TOP = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            done,
   input logic [PA_W-1:0] done_pa,
   input logic [3:0]      done_perm,
   input logic [2:0]      done_level,
   input logic [2:0]      done_fault
);
   assert_mode_fault_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault == 3'd1) |-> (done_level == 3'd0));

   assert_read_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

   assert_level_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (32'(done_level) <= MAX_TOP));

   assert_misalign_above_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault == 3'd4) |-> (done_level != 3'd0));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_fault_zero_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault != 3'd0) |-> (done_pa == '0 && done_perm == 4'd0));

   assert_read_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   assert_idle_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid);
endmodule

bind iopt_walker iopt_walker_chk #(.PA_W(PA_W), .MAX_TOP(MAX_TOP)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_addr(mem_req_addr), .done(done), .done_pa(done_pa),
   .done_perm(done_perm), .done_level(done_level), .done_fault(done_fault)
);

// File: tb/iopt_walker_test.sv
module iopt_walker_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [63:0] req_iova;
   logic [3:0]  cfg_mode;
   logic [43:0] cfg_root_ppn;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [55:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [63:0] mem_rsp_data;
   logic        done;
   logic [55:0] done_pa;
   logic [3:0]  done_perm;
   logic [2:0]  done_level;
   logic [2:0]  done_fault;

   int tests = 0;
   int fails = 0;

   logic [63:0] mem [logic [55:0]];
   logic [55:0] alog [$];
   logic        rdy_tog;

   logic        r_seen;
   logic [55:0] r_pa;
   logic [3:0]  r_perm;
   logic [2:0]  r_lvl;
   logic [2:0]  r_flt;
   int          r_reads;
   logic [55:0] r_first;

   localparam logic [63:0] ROOT = 64'h100;

   always #5 clk = ~clk;

   assign mem_req_ready = rdy_tog;

   iopt_walker uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_iova(req_iova), .cfg_mode(cfg_mode), .cfg_root_ppn(cfg_root_ppn),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .done(done), .done_pa(done_pa),
      .done_perm(done_perm), .done_level(done_level), .done_fault(done_fault)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         rdy_tog       <= 1'b0;
         mem_rsp_valid <= 1'b0;
         mem_rsp_data  <= '0;
      end else begin
         rdy_tog <= ~rdy_tog;
         if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'd0;
            alog.push_back(mem_req_addr);
         end else begin
            mem_rsp_valid <= 1'b0;
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] canon(input logic [63:0] p, input int top);
      int sh;
      logic signed [63:0] t;
      sh = 63 - (9 * top + 20);
      t  = $signed(p << sh);
      return t >>> sh;
   endfunction

   function automatic logic [63:0] idx_of(input logic [63:0] va, input int lv);
      return (va >> (12 + 9 * lv)) & 64'h1FF;
   endfunction

   function automatic logic [55:0] addr_of(input logic [63:0] va, input int top, input int lv);
      return 56'(((ROOT + 64'(top - lv)) << 12) + idx_of(va, lv) * 8);
   endfunction

   task automatic build_chain(input logic [63:0] va, input int top, input int leaf_lv,
                              input logic [63:0] leaf_e);
      for (int lv = top; lv >= leaf_lv; lv--) begin
         if (lv == leaf_lv) mem[addr_of(va, top, lv)] = leaf_e;
         else mem[addr_of(va, top, lv)] = ((ROOT + 64'(top - lv + 1)) << 10) | 64'd1;
      end
   endtask

   task automatic walk(input logic [63:0] va, input logic [3:0] mode);
      int start;
      int cnt;
      @(negedge clk);
      req_valid    = 1'b1;
      req_iova     = va;
      cfg_mode     = mode;
      cfg_root_ppn = ROOT[43:0];
      start        = alog.size();
      @(negedge clk);
      req_valid = 1'b0;
      cnt = 0;
      while (!done && cnt < 400) begin
         @(negedge clk);
         cnt++;
      end
      r_seen  = done;
      r_pa    = done_pa;
      r_perm  = done_perm;
      r_lvl   = done_level;
      r_flt   = done_fault;
      r_reads = alog.size() - start;
      r_first = (r_reads > 0) ? alog[start] : 56'd0;
      chk("R9 done seen", 64'(r_seen), 64'd1);
      @(negedge clk);
      chk("R9 done one cycle", 64'(done), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [63:0] va;
      logic [63:0] ppn;
      logic [63:0] ent;
      logic [63:0] mask;
      logic [2:0]  rwx;
      logic        u;
      int          top;

      rst_n = 1'b0;
      req_valid = 1'b0;
      req_iova = '0;
      cfg_mode = '0;
      cfg_root_ppn = '0;
      repeat (3) @(negedge clk);
      chk("R9 reset ready", 64'(req_ready), 64'd1);
      chk("R9 reset done", 64'(done), 64'd0);
      chk("R10 reset no read", 64'(mem_req_valid), 64'd0);
      rst_n = 1'b1;

      // R1 R3 R5 R6: every mode, leaf at every level
      for (int mode = 8; mode <= 10; mode++) begin
         top = mode - 6;
         for (int lv = 0; lv <= top; lv++) begin
            mem.delete();
            va   = canon(64'h9E37_79B9_7F4A_7C15 * 64'(mode * 7 + lv + 1), top);
            rwx  = 3'((lv + mode) % 8);
            if (lv > 0 && rwx == 3'd0) rwx = 3'd1;
            u    = lv[0];
            ppn  = 64'h5B << (9 * lv);
            ent  = (ppn << 10) | 64'(u) << 4 | 64'(rwx) << 1 | 64'd1 |
                   64'h2000_0000_0000_03E0;
            build_chain(va, top, lv, ent);
            walk(va, 4'(mode));
            mask = (64'd1 << (12 + 9 * lv)) - 64'd1;
            chk("R5 fault none", 64'(r_flt), 64'd0);
            chk("R6 superpage pa", 64'(r_pa), ((ppn << 12) | (va & mask)) & 64'h00FF_FFFF_FFFF_FFFF);
            chk("R5 perm", 64'(r_perm), 64'({u, rwx}));
            chk("R5 level", 64'(r_lvl), 64'(lv));
            chk("R3 read count", 64'(r_reads), 64'(top - lv + 1));
            chk("R1 first read addr", 64'(r_first), (ROOT << 12) + idx_of(va, top) * 8);
         end
      end

      // R1: unsupported codes
      mem.delete();
      walk(64'h1000, 4'd7);
      chk("R1 mode 7 fault", 64'(r_flt), 64'd1);
      chk("R1 mode 7 no read", 64'(r_reads), 64'd0);
      chk("R1 mode 7 level", 64'(r_lvl), 64'd0);
      walk(64'h1000, 4'd11);
      chk("R1 mode 11 fault", 64'(r_flt), 64'd1);
      chk("R9 fault pa zero", 64'(r_pa), 64'd0);

      // R2: non-canonical addresses
      va = canon(64'h0000_0045_6789_A000, 2) ^ (64'd1 << 39);
      walk(va, 4'd8);
      chk("R2 sign fault 39", 64'(r_flt), 64'd2);
      chk("R2 no read", 64'(r_reads), 64'd0);
      chk("R2 level", 64'(r_lvl), 64'd2);
      va = canon(64'h0123_4567_89AB_C000, 4) ^ (64'd1 << 57);
      walk(va, 4'd10);
      chk("R2 sign fault 57", 64'(r_flt), 64'd2);
      // R2 R4: canonical negative address walks, root entry empty
      walk(64'hFFFF_8000_0000_1000, 4'd9);
      chk("R4 absent at top", 64'(r_flt), 64'd3);
      chk("R4 absent level", 64'(r_lvl), 64'd3);
      chk("R2 canonical accepted read", 64'(r_reads), 64'd1);

      // R4: V clear deeper in the walk
      mem.delete();
      va = canon(64'h0000_0012_3456_7000, 2);
      build_chain(va, 2, 1, 64'hFFFF_FFFF_FFFF_FFFE);
      walk(va, 4'd8);
      chk("R4 absent level 1 fault", 64'(r_flt), 64'd3);
      chk("R4 absent level 1 level", 64'(r_lvl), 64'd1);
      chk("R9 absent perm zero", 64'(r_perm), 64'd0);

      // R6: misaligned superpages
      mem.delete();
      build_chain(va, 2, 2, (((64'h5B << 18) | 64'h100) << 10) | 64'h3);
      walk(va, 4'd8);
      chk("R6 misaligned level 2", 64'(r_flt), 64'd4);
      chk("R6 misaligned pa zero", 64'(r_pa), 64'd0);
      mem.delete();
      build_chain(va, 2, 1, (((64'h5B << 9) | 64'h1) << 10) | 64'h3);
      walk(va, 4'd8);
      chk("R6 misaligned level 1", 64'(r_flt), 64'd4);

      // R5: level 0 entry with no access bits is still a leaf
      mem.delete();
      build_chain(va, 2, 0, (64'h777 << 10) | 64'h11);
      walk(va, 4'd8);
      chk("R5 bare leaf fault", 64'(r_flt), 64'd0);
      chk("R5 bare leaf perm", 64'(r_perm), 64'h8);
      chk("R5 bare leaf pa", 64'(r_pa), (64'h777 << 12) | (va & 64'hFFF));

      // R7: 64 KiB contiguous leaf
      mem.delete();
      va = canon(64'h0000_0012_3456_B9A4, 2);
      ppn = 64'hABCD8;
      build_chain(va, 2, 0, (64'd1 << 63) | (ppn << 10) | 64'h3);
      walk(va, 4'd8);
      chk("R7 napot fault", 64'(r_flt), 64'd0);
      chk("R7 napot pa", 64'(r_pa), ((ppn >> 4) << 16) | (va & 64'hFFFF));
      chk("R7 napot perm", 64'(r_perm), 64'h1);

      // R8: illegal uses of the N bit
      mem.delete();
      build_chain(va, 2, 0, (64'd1 << 63) | (64'hABCD0 << 10) | 64'h3);
      walk(va, 4'd8);
      chk("R8 missing marker", 64'(r_flt), 64'd5);
      chk("R8 missing marker level", 64'(r_lvl), 64'd0);
      mem.delete();
      build_chain(va, 2, 1, (64'd1 << 63) | ((64'h5B << 9) << 10) | 64'h3);
      walk(va, 4'd8);
      chk("R8 N above level 0", 64'(r_flt), 64'd5);
      chk("R8 N above level 0 level", 64'(r_lvl), 64'd1);
      mem.delete();
      build_chain(va, 2, 0, (ppn << 10) | 64'h3);
      mem[addr_of(va, 2, 2)] = mem[addr_of(va, 2, 2)] | (64'd1 << 63);
      walk(va, 4'd8);
      chk("R8 N on pointer", 64'(r_flt), 64'd5);
      chk("R8 N on pointer level", 64'(r_lvl), 64'd2);
      chk("R10 one read before fault", 64'(r_reads), 64'd1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule